// File: doc/BRIEF.md
# Microcode Sequencer with One-Hot Control Decode

This block is the control heart of a small processor whose data words are four bits wide. It holds the current machine opcode in an instruction register and counts micro-steps inside that instruction. Opcode and step together form a micro-address. A constant microcode table maps each micro-address to one of 22 micro-operations. The block then decodes that micro-operation into 22 separate control strobes. Datapath units such as the accumulator, the address register, the program counter, the ALU and memory each watch their own strobes.

Timing follows a non-overlapping two-phase scheme, sampled on a fast system clock. While the first phase is low, the selected strobe is driven. While the first phase is high, all strobes are off. A high-to-low transition of the second phase commits state. On that edge the fetch micro-operation loads a new opcode from the data bus and clears the step counter. The halt micro-operation holds the counter until a start request is seen. Every other micro-operation advances the step counter by one.

After reset the block sits at micro-address 0x00, which holds the halt operation. A start request moves it to the fetch word of that same sequence, so the first real instruction is loaded from the bus.

Top module: `microseq_ctrl`

## Requirements
- R1: After reset, the micro-address output is 0x00 and the halted output is 1.
- R2: The micro-address output is the opcode register in bits 7:4 and the step counter in bits 3:0.
- R3: Micro-operation codes are: halt 0x00, fetch 0x01, accumulator-low read 0x02, accumulator-high read 0x03, address-low load 0x04, address-high load 0x05, accumulator-low write 0x06, accumulator-high write 0x07, PC-low write 0x08, PC-high write 0x09, jump 0x0A, jump-if-no-carry 0x0B, jump-if-no-data 0x0C, jump-if-not-zero 0x0D, AND 0x0E, OR 0x0F, ADD 0x10, SUB 0x11, compare 0x12, rotate-left 0x13, rotate-right 0x14, clear-flags 0x15. Control bit k is the strobe of the operation whose code is k.
- R4: While phase1 is high, all control bits are 0. While phase1 is low, exactly one control bit is 1.
- R5: Opcode and step change only at a phase2 high-to-low transition. While phase2 is held high, the micro-address is stable.
- R6: At a commit where the current operation is fetch, the opcode register takes data_bus and the step counter becomes 0.
- R7: At a commit where the current operation is neither fetch nor halt, the step counter increments by one and the opcode is unchanged.
- R8: At a commit where the current operation is halt, the step counter holds unless start is 1, in which case it increments by one. The halted output is 1 exactly when the current operation is halt.
- R9: Sequences, by opcode:
  - 0: halt, fetch.
  - 1: address-low, address-high, acc-low read, acc-high read, fetch.
  - 2: address-low, address-high, acc-low write, acc-high write, fetch.
  - 3: address-low, address-high, jump, fetch.
  - 4: address-low, address-high, PC-low write, PC-high write, fetch.
  - 5 to C: address-low, address-high, then one operation, then fetch. The operation is AND for 5, OR for 6, ADD for 7, SUB for 8, jump-if-not-zero for 9, compare for A, jump-if-no-data for B and jump-if-no-carry for C.
  - D: rotate-left, fetch.
  - E: rotate-right, fetch.
  - F: clear-flags, fetch.
- R10: data_bus has no effect at commits whose current operation is not fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples both phases |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase1 | input | 1 | First phase; strobes are driven while it is low |
| phase2 | input | 1 | Second phase; its falling transition commits state |
| start | input | 1 | Request to leave the halt operation |
| data_bus | input | 4 | Opcode source for the fetch operation |
| ctrl | output | 22 | One-hot micro-operation strobes |
| uaddr | output | 8 | Current micro-address {opcode, step} |
| halted | output | 1 | Current operation is halt |

## Verification
The bench builds the block with its default widths: a 4-bit opcode, a 4-bit step counter and 22 operations. At these widths, a program made of all sixteen opcodes walks every populated word of the microcode table. The bench checks every word at the ports, both with the strobes gated off and with them driven. It also checks halt with and without start, a long phase2 high period, junk on the data bus at non-fetch commits, and a reset in the middle of an instruction.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int OPCODE_BITS = 4;
  localparam int STEP_BITS   = 4;
  localparam int UOP_COUNT   = 22;
  localparam int UOP_BITS    = $clog2(UOP_COUNT);

  typedef enum logic [UOP_BITS-1:0] {
    U_HALT      = 5'h00,
    U_FETCH     = 5'h01,
    U_ACC_LO_RD = 5'h02,
    U_ACC_HI_RD = 5'h03,
    U_ADR_LO    = 5'h04,
    U_ADR_HI    = 5'h05,
    U_ACC_LO_WR = 5'h06,
    U_ACC_HI_WR = 5'h07,
    U_PC_LO_WR  = 5'h08,
    U_PC_HI_WR  = 5'h09,
    U_JUMP      = 5'h0A,
    U_JUMP_NC   = 5'h0B,
    U_JUMP_ND   = 5'h0C,
    U_JUMP_NZ   = 5'h0D,
    U_AND       = 5'h0E,
    U_OR        = 5'h0F,
    U_ADD       = 5'h10,
    U_SUB       = 5'h11,
    U_CMP       = 5'h12,
    U_ROT_L     = 5'h13,
    U_ROT_R     = 5'h14,
    U_CLR_FLAGS = 5'h15
  } uop_e;

endpackage

// File: rtl/phase_commit.sv
module phase_commit (
  input  logic clk,
  input  logic rst_n,
  input  logic phase2,
  output logic commit
);

  logic ph2_q;
  logic ph2_d;

  always_comb begin
    ph2_d = phase2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph2_q <= 1'b0;
    end else begin
      ph2_q <= ph2_d;
    end
  end

  // falling transition of the second phase
  assign commit = ph2_q & ~phase2;

endmodule

// File: rtl/useq_state.sv
module useq_state
  import useq_pkg::*;
#(
  parameter int OP_W   = OPCODE_BITS,
  parameter int STEP_W = STEP_BITS,
  parameter int UOP_W  = UOP_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic              start,
  input  logic [UOP_W-1:0]  uop,
  input  logic [OP_W-1:0]   data_bus,
  output logic [OP_W-1:0]   opcode,
  output logic [STEP_W-1:0] step
);

  logic [OP_W-1:0]   opcode_d;
  logic [STEP_W-1:0] step_d;
  logic              is_fetch;
  logic              is_halt;
  logic              state_en;

  assign is_fetch = (uop == U_FETCH);
  assign is_halt  = (uop == U_HALT);
  assign state_en = commit;

  always_comb begin
    opcode_d = opcode;
    step_d   = step;
    if (is_fetch) begin
      opcode_d = data_bus;
      step_d   = '0;
    end else if (is_halt) begin
      if (start) begin
        step_d = step + STEP_W'(1);
      end
    end else begin
      step_d = step + STEP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opcode <= '0;
      step   <= '0;
    end else if (state_en) begin
      opcode <= opcode_d;
      step   <= step_d;
    end
  end

  assert_fetch_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && uop == U_FETCH) |=> (step == '0 && opcode == $past(data_bus)));

  assert_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && uop != U_FETCH && uop != U_HALT) |=>
      (step == STEP_W'($past(step) + STEP_W'(1)) && $stable(opcode)));

  assert_halt_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && uop == U_HALT && !start) |=> ($stable(step) && $stable(opcode)));

  assert_hold_between_commits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(step) && $stable(opcode)));

endmodule

// File: rtl/ucode_rom.sv
module ucode_rom
  import useq_pkg::*;
#(
  parameter int OP_W   = OPCODE_BITS,
  parameter int STEP_W = STEP_BITS,
  parameter int UOP_W  = UOP_BITS
) (
  input  logic [OP_W-1:0]   opcode,
  input  logic [STEP_W-1:0] step,
  output logic [UOP_W-1:0]  uop
);

  uop_e body_a;
  uop_e body_b;
  logic long_body;
  logic addr_prefix;
  uop_e word;

  // operand-fetching opcodes: body that follows the two address loads
  always_comb begin
    body_a      = U_HALT;
    body_b      = U_FETCH;
    long_body   = 1'b0;
    addr_prefix = 1'b1;
    case (opcode)
      OP_W'(1):  begin body_a = U_ACC_LO_RD; body_b = U_ACC_HI_RD; long_body = 1'b1; end
      OP_W'(2):  begin body_a = U_ACC_LO_WR; body_b = U_ACC_HI_WR; long_body = 1'b1; end
      OP_W'(3):  body_a = U_JUMP;
      OP_W'(4):  begin body_a = U_PC_LO_WR;  body_b = U_PC_HI_WR;  long_body = 1'b1; end
      OP_W'(5):  body_a = U_AND;
      OP_W'(6):  body_a = U_OR;
      OP_W'(7):  body_a = U_ADD;
      OP_W'(8):  body_a = U_SUB;
      OP_W'(9):  body_a = U_JUMP_NZ;
      OP_W'(10): body_a = U_CMP;
      OP_W'(11): body_a = U_JUMP_ND;
      OP_W'(12): body_a = U_JUMP_NC;
      OP_W'(13): begin body_a = U_ROT_L;     addr_prefix = 1'b0; end
      OP_W'(14): begin body_a = U_ROT_R;     addr_prefix = 1'b0; end
      OP_W'(15): begin body_a = U_CLR_FLAGS; addr_prefix = 1'b0; end
      default:   begin body_a = U_HALT;      addr_prefix = 1'b0; end
    endcase
  end

  // word selection by step; unused steps fall back to halt
  always_comb begin
    word = U_HALT;
    if (addr_prefix) begin
      case (step)
        STEP_W'(0): word = U_ADR_LO;
        STEP_W'(1): word = U_ADR_HI;
        STEP_W'(2): word = body_a;
        STEP_W'(3): word = long_body ? body_b : U_FETCH;
        STEP_W'(4): word = long_body ? U_FETCH : U_HALT;
        default:    word = U_HALT;
      endcase
    end else begin
      case (step)
        STEP_W'(0): word = body_a;
        STEP_W'(1): word = U_FETCH;
        default:    word = U_HALT;
      endcase
    end
  end

  assign uop = word;

endmodule

// File: rtl/uop_onehot.sv
module uop_onehot
  import useq_pkg::*;
#(
  parameter int UOP_W = UOP_BITS,
  parameter int N_UOP = UOP_COUNT
) (
  input  logic [UOP_W-1:0] uop,
  input  logic             drive_n,
  output logic [N_UOP-1:0] ctrl
);

  for (genvar k = 0; k < N_UOP; k++) begin : g_line
    assign ctrl[k] = !drive_n && (uop == UOP_W'(k));
  end

endmodule

// File: rtl/microseq_ctrl.sv
module microseq_ctrl
  import useq_pkg::*;
#(
  parameter int OP_W     = OPCODE_BITS,
  parameter int STEP_W   = STEP_BITS,
  parameter int NUM_UOPS = UOP_COUNT
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     phase1,
  input  logic                     phase2,
  input  logic                     start,
  input  logic [OP_W-1:0]          data_bus,
  output logic [NUM_UOPS-1:0]      ctrl,
  output logic [OP_W+STEP_W-1:0]   uaddr,
  output logic                     halted
);

  localparam int UOP_W = $clog2(NUM_UOPS);

  logic              rst_meta_n;
  logic              rst_core_n;
  logic              commit;
  logic [OP_W-1:0]   opcode;
  logic [STEP_W-1:0] step;
  logic [UOP_W-1:0]  uop;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_core_n <= rst_meta_n;
    end
  end

  phase_commit i_commit (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .phase2 (phase2),
    .commit (commit)
  );

  useq_state #(.OP_W(OP_W), .STEP_W(STEP_W), .UOP_W(UOP_W)) i_state (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .commit   (commit),
    .start    (start),
    .uop      (uop),
    .data_bus (data_bus),
    .opcode   (opcode),
    .step     (step)
  );

  ucode_rom #(.OP_W(OP_W), .STEP_W(STEP_W), .UOP_W(UOP_W)) i_rom (
    .opcode (opcode),
    .step   (step),
    .uop    (uop)
  );

  uop_onehot #(.UOP_W(UOP_W), .N_UOP(NUM_UOPS)) i_decode (
    .uop     (uop),
    .drive_n (phase1),
    .ctrl    (ctrl)
  );

  assign uaddr  = {opcode, step};
  assign halted = (uop == U_HALT);

  assert_ctrl_gated_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    phase1 |-> (ctrl == '0));

  assert_ctrl_onehot_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    !phase1 |-> ($countones(ctrl) == 1));

  assert_halt_flag_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!phase1 && halted) |-> ctrl[0]);

  assert_uaddr_stable_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (phase2 && $past(phase2)) |-> $stable(uaddr));

endmodule

// File: tb/test_microseq_ctrl.sv
`timescale 1ns/1ps
module test_microseq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        phase1;
  logic        phase2;
  logic        start;
  logic [3:0]  data_bus;
  logic [21:0] ctrl;
  logic [7:0]  uaddr;
  logic        halted;

  int checks = 0;
  int errors = 0;
  int e_op = 0;
  int e_st = 0;

  always #2.5 clk = ~clk;

  microseq_ctrl i_microseq_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase1   (phase1),
    .phase2   (phase2),
    .start    (start),
    .data_bus (data_bus),
    .ctrl     (ctrl),
    .uaddr    (uaddr),
    .halted   (halted)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // expected micro-operation per R3/R9
  function automatic int exp_uop(input int op, input int st);
    int body;
    int body2;
    bit lng;
    body = 0; body2 = 1; lng = 0;
    if (op == 0) return (st == 0) ? 0 : (st == 1) ? 1 : 0;
    if (op >= 13) return (st == 0) ? (op == 13 ? 8'h13 : op == 14 ? 8'h14 : 8'h15)
                                   : (st == 1) ? 1 : 0;
    case (op)
      1: begin body = 2; body2 = 3; lng = 1; end
      2: begin body = 6; body2 = 7; lng = 1; end
      3: body = 8'h0A;
      4: begin body = 8; body2 = 9; lng = 1; end
      5: body = 8'h0E;
      6: body = 8'h0F;
      7: body = 8'h10;
      8: body = 8'h11;
      9: body = 8'h0D;
      10: body = 8'h12;
      11: body = 8'h0C;
      default: body = 8'h0B;
    endcase
    case (st)
      0: return 4;
      1: return 5;
      2: return body;
      3: return lng ? body2 : 1;
      4: return lng ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic ucycle(input logic st_in, input logic [3:0] bus_in);
    int u;
    logic [7:0] a0;
    u = exp_uop(e_op, e_st);
    @(negedge clk);
    start = st_in; data_bus = bus_in; phase1 = 1'b1; phase2 = 1'b0;
    @(negedge clk);
    chk(ctrl == '0, "R4 gated", ctrl, 0);
    phase1 = 1'b0;
    @(negedge clk);
    chk(uaddr == 8'((e_op << 4) | e_st), "R2/R9/R10 uaddr", uaddr, (e_op << 4) | e_st);
    chk(ctrl == (22'd1 << u), "R3/R9 ctrl", ctrl, 22'd1 << u);
    chk(halted == (u == 0), "R8 halted", halted, (u == 0));
    a0 = uaddr;
    phase1 = 1'b1;
    @(negedge clk);
    phase2 = 1'b1;
    repeat (3) @(negedge clk);
    chk(uaddr == a0, "R5 stable", uaddr, a0);
    phase2 = 1'b0;
    repeat (2) @(negedge clk);
    if (u == 1) begin e_op = bus_in; e_st = 0; end
    else if (u == 0) begin if (st_in) e_st = (e_st + 1) % 16; end
    else e_st = (e_st + 1) % 16;
  endtask

  task automatic run_instr(input logic [3:0] next_op);
    for (int g = 0; g < 20 && exp_uop(e_op, e_st) != 1; g++) begin
      ucycle(1'b0, 4'(e_st) ^ 4'hA ^ 4'(e_op));
    end
    ucycle(1'b0, next_op);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    e_op = 0; e_st = 0;
    phase1 = 1'b0;
    @(negedge clk);
    chk(uaddr == 8'h00, "R1 uaddr", uaddr, 0);
    chk(halted == 1'b1, "R1 halted", halted, 1);
    phase1 = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; phase1 = 1'b1; phase2 = 1'b0; start = 1'b0; data_bus = 4'h0;
    do_reset();
    // R8: halt without start holds
    ucycle(1'b0, 4'h7);
    ucycle(1'b0, 4'h3);
    // R8: start leaves halt, fetch of opcode 1
    ucycle(1'b1, 4'h5);
    ucycle(1'b0, 4'h1);
    // R9/R6/R7/R10: every opcode in turn, then back to 0
    for (int p = 2; p <= 15; p++) run_instr(4'(p));
    run_instr(4'h0);
    // R8: halted at 0x00 again
    ucycle(1'b0, 4'hF);
    ucycle(1'b0, 4'h9);
    ucycle(1'b1, 4'h0);
    ucycle(1'b0, 4'h2);
    ucycle(1'b0, 4'hC);
    ucycle(1'b0, 4'h3);
    // R1: reset in the middle of an instruction
    do_reset();
    ucycle(1'b1, 4'h0);
    ucycle(1'b0, 4'hE);
    run_instr(4'h0);
    ucycle(1'b0, 4'h1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule